// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block carries one processor operand (one, two, three or four bytes, at any byte address) across a 32-bit external data bus whose far side may be an 8-, 16- or 32-bit port. It starts the first bus cycle with a size code that gives the whole operand length and with the operand address. It then waits for the two-bit acknowledge from the memory. The acknowledge reports how wide the responding port is, and from that the block works out how many bytes that cycle moved.

Every later cycle is planned again from the port width just reported. Its size code gives the bytes still to go, not the bytes that fit the port, and its address is the old one advanced by the bytes moved. On writes, operand bytes are copied across the byte lanes so that a port of any width finds its bytes on the lanes it connects to. On reads, the bytes that arrive are gathered most significant first. A one-cycle done pulse presents the assembled operand.

Top module: `bsz_sequencer`

## Requirements
- R1: While reset is held and after it is released, busy and done are 0 until a transfer is started.
- R2: A start pulse while idle begins a bus cycle in the next clock. That cycle shows the operand address on bus_addr and the operand's own size code on bus_siz.
- R3: The acknowledge ack_n = {port-hi, port-lo} is active low: 00 = 32-bit port, 01 = 16-bit port, 10 = 8-bit port, 11 = wait. A wait cycle leaves busy, bus_addr and bus_siz unchanged.
- R4: On each acknowledge, the bytes moved equal the smaller of two counts: the bytes remaining, and the port width minus (address mod port width). The next cycle shows bus_addr advanced by that amount and bus_siz coding the new remainder.
- R5: On writes, lane L (lane 0 = bits 31:24) carries operand byte j, where bytes are counted from the next byte still to send. If L ≥ addr[1:0], then j = L − addr[1:0]. Otherwise, if L < 2 and L ≥ addr[0], then j = L − addr[0]. In every other case j = 0. With this rule an 8-, 16- or 32-bit port stores the correct bytes.
- R6: On reads, byte k of a cycle comes from lane (addr+k) mod port width, where lane 0 = bits 31:24 and the 8-bit port uses lane 0. Bytes are shifted in most significant first, and rd_result holds the operand right-justified with zeros above it. rd_result changes only together with done.
- R7: done is high for exactly one clock, in the clock after the last acknowledge. busy is 0 in that clock.
- R8: A start pulse while busy is ignored. The transfer in progress keeps its address and size.
- R9: bus_addr advances modulo 2^ADDR_W.
- R10: Size codes on op_size and bus_siz are 01 = one byte, 10 = two, 11 = three, 00 = four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| op_addr | input | ADDR_W | Operand byte address |
| op_size | input | 2 | Operand size code |
| op_write | input | 1 | 1 = write operand, 0 = read |
| op_wdata | input | 32 | Write operand, right-justified |
| ack_n | input | 2 | Port-size acknowledge, active low |
| bus_rdata | input | 32 | Read data from the bus lanes |
| busy | output | 1 | A bus cycle is in progress |
| bus_read | output | 1 | Direction of the current transfer |
| bus_siz | output | 2 | Size code of bytes still to move |
| bus_addr | output | ADDR_W | Current byte address |
| bus_wdata | output | 32 | Lane-steered write data |
| done | output | 1 | One-cycle completion pulse |
| rd_result | output | 32 | Assembled read operand |

## Verification
The bench builds the block with ADDR_W = 8. This keeps a full 256-byte memory model in the bench and lets operands straddle the 0xFF to 0x00 wrap. It sweeps every size and eight consecutive start addresses against each of the three port widths, for both reads and writes, so every alignment and every split point is reached. Odd start addresses add a wait cycle to each bus cycle, with a stray start pulse inside it.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
   localparam int LANES  = 4;
   localparam int DATA_W = 8 * LANES;

   typedef enum logic [1:0] {
      PORT8     = 2'd0,
      PORT16    = 2'd1,
      PORT32    = 2'd2,
      PORT_WAIT = 2'd3
   } port_e;

   function automatic logic [2:0] size_to_count(input logic [1:0] code);
      return (code == 2'b00) ? 3'd4 : {1'b0, code};
   endfunction
endpackage

// File: rtl/bsz_port_plan.sv
module bsz_port_plan
   import bsz_pkg::*;
(
   input  logic [1:0] ack_n,
   input  logic [1:0] addr_lo,
   input  logic [2:0] remain,
   output port_e      port,
   output logic [2:0] moved
);
   logic [2:0] room;

   always_comb begin
      unique case (ack_n)
         2'b00:   port = PORT32;
         2'b01:   port = PORT16;
         2'b10:   port = PORT8;
         default: port = PORT_WAIT;
      endcase
      unique case (port)
         PORT32:  room = 3'd4 - {1'b0, addr_lo};
         PORT16:  room = 3'd2 - {2'b00, addr_lo[0]};
         PORT8:   room = 3'd1;
         default: room = 3'd0;
      endcase
      moved = (remain < room) ? remain : room;
   end
endmodule

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer
   import bsz_pkg::*;
(
   input  logic [DATA_W-1:0] wbuf,
   input  logic [1:0]        addr_lo,
   output logic [DATA_W-1:0] lanes
);
   function automatic logic [1:0] pick(input int lane, input logic [1:0] a);
      if (lane >= int'(a))
         return 2'(lane - int'(a));
      else if (lane < 2 && lane >= int'(a[0]))
         return 2'(lane - int'(a[0]));
      else
         return 2'd0;
   endfunction

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic [1:0]        j;
      logic [DATA_W-1:0] sh;
      always_comb begin
         j  = pick(L, addr_lo);
         sh = wbuf << {j, 3'b000};
      end
      assign lanes[DATA_W-1-8*L -: 8] = sh[DATA_W-1 -: 8];
   end
endmodule

// File: rtl/bsz_rd_pack.sv
module bsz_rd_pack
   import bsz_pkg::*;
(
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] rdata,
   input  port_e             port,
   input  logic [1:0]        addr_lo,
   input  logic [2:0]        moved,
   output logic [DATA_W-1:0] acc_next
);
   logic [1:0]        off;
   logic [1:0]        ln;
   logic [DATA_W-1:0] sh;

   always_comb begin
      acc_next = acc;
      off      = 2'd0;
      ln       = 2'd0;
      sh       = '0;
      for (int k = 0; k < LANES; k++) begin
         if (3'(k) < moved) begin
            off = addr_lo + 2'(k);
            unique case (port)
               PORT32:  ln = off;
               PORT16:  ln = {1'b0, off[0]};
               default: ln = 2'd0;
            endcase
            sh       = rdata << {ln, 3'b000};
            acc_next = {acc_next[DATA_W-9:0], sh[DATA_W-1 -: 8]};
         end
      end
   end
endmodule

// File: rtl/bsz_sequencer.sv
module bsz_sequencer
   import bsz_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [1:0]        op_size,
   input  logic              op_write,
   input  logic [31:0]       op_wdata,
   input  logic [1:0]        ack_n,
   input  logic [31:0]       bus_rdata,
   output logic              busy,
   output logic              bus_read,
   output logic [1:0]        bus_siz,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   output logic              done,
   output logic [31:0]       rd_result
);
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("bsz_sequencer: ADDR_W must be at least 2");
   end

   logic [2:0]        remain;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       wbuf;
   logic [31:0]       acc;
   logic              wr_q;
   port_e             port;
   logic [2:0]        moved;
   logic [31:0]       acc_next;
   logic [31:0]       steer;
   logic [2:0]        n_start;

   assign n_start = size_to_count(op_size);

   bsz_port_plan u_plan (
      .ack_n   (ack_n),
      .addr_lo (addr_q[1:0]),
      .remain  (remain),
      .port    (port),
      .moved   (moved)
   );

   bsz_wr_steer u_steer (
      .wbuf    (wbuf),
      .addr_lo (addr_q[1:0]),
      .lanes   (steer)
   );

   bsz_rd_pack u_pack (
      .acc      (acc),
      .rdata    (bus_rdata),
      .port     (port),
      .addr_lo  (addr_q[1:0]),
      .moved    (moved),
      .acc_next (acc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         remain    <= 3'd0;
         addr_q    <= '0;
         wbuf      <= '0;
         acc       <= '0;
         wr_q      <= 1'b0;
         rd_result <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy   <= 1'b1;
               remain <= n_start;
               addr_q <= op_addr;
               wbuf   <= op_wdata << {3'd4 - n_start, 3'b000};
               acc    <= '0;
               wr_q   <= op_write;
            end
         end else if (moved != 3'd0) begin
            remain <= remain - moved;
            addr_q <= addr_q + ADDR_W'(moved);
            wbuf   <= wbuf << {moved, 3'b000};
            acc    <= acc_next;
            if (moved == remain) begin
               busy      <= 1'b0;
               done      <= 1'b1;
               rd_result <= wr_q ? 32'd0 : acc_next;
            end
         end
      end
   end

   assign bus_siz   = remain[1:0];
   assign bus_addr  = addr_q;
   assign bus_read  = ~wr_q;
   assign bus_wdata = (busy && wr_q) ? steer : 32'd0;
endmodule

// File: rtl/bsz_seq_chk.sv
module bsz_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        ack_n,
   input logic              busy,
   input logic              done,
   input logic [1:0]        bus_siz,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       rd_result
);
   function automatic int cnt(input logic [1:0] c);
      return (c == 2'b00) ? 4 : int'(c);
   endfunction

   // R3 and R8: a wait cycle, even one carrying a stray start, changes nothing
   p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ack_n == 2'b11) |=> (busy && $stable(bus_addr) && $stable(bus_siz)));

   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && ack_n == 2'b11) |=> $stable(bus_addr));

   // R4: every acknowledge shrinks the remaining count or ends the transfer
   p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ack_n != 2'b11) |=> (!busy || cnt(bus_siz) < cnt($past(bus_siz))));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_result) |-> done);
endmodule

bind bsz_sequencer bsz_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .ack_n     (ack_n),
   .busy      (busy),
   .done      (done),
   .bus_siz   (bus_siz),
   .bus_addr  (bus_addr),
   .rd_result (rd_result)
);

// File: tb/bsz_sequencer_bench.sv
module bsz_sequencer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] op_addr = '0;
   logic [1:0]    op_size = 2'b00;
   logic          op_write = 1'b0;
   logic [31:0]   op_wdata = '0;
   logic [1:0]    ack_n = 2'b11;
   logic [31:0]   bus_rdata = '0;
   logic          busy, bus_read, done;
   logic [1:0]    bus_siz;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_wdata, rd_result;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] mem [256];
   logic [7:0] wmem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   bsz_sequencer #(.ADDR_W(AW)) u_bsz_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start), .op_addr(op_addr),
      .op_size(op_size), .op_write(op_write), .op_wdata(op_wdata),
      .ack_n(ack_n), .bus_rdata(bus_rdata), .busy(busy), .bus_read(bus_read),
      .bus_siz(bus_siz), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .done(done), .rd_result(rd_result)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [AW-1:0] a0, input int n, input bit wr,
                       input int pw, input bit waits);
      int rem;
      logic [AW-1:0] a;
      logic [31:0] exp;
      logic [1:0] code;
      int mv;
      int room;
      code = (pw == 4) ? 2'b00 : (pw == 2) ? 2'b01 : 2'b10;
      for (int i = 0; i < 256; i++) wmem[i] = 8'hEE;
      @(negedge clk);
      op_addr  = a0;
      op_size  = 2'(n);
      op_write = wr;
      op_wdata = 32'h5A000000 ^ {24'h13579B, a0} ^ (32'(n) << 12);
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      rem = n;
      a = a0;
      while (rem > 0) begin
         // R2/R10 on the first cycle, R4/R9 afterwards
         chk(busy == 1'b1, "R2 busy during cycle", 32'(busy), 1);
         chk(bus_siz == 2'(rem), "R10 size code of remainder", 32'(bus_siz), 32'(rem[1:0]));
         chk(bus_addr == a, "R4 R9 cycle address", 32'(bus_addr), 32'(a));
         if (waits) begin
            ack_n = 2'b11;
            start = 1'b1;
            op_addr = a + 8'd77;
            @(negedge clk);
            start = 1'b0;
            chk(busy && bus_addr == a && bus_siz == 2'(rem), "R3 R8 wait holds cycle",
                32'(bus_addr), 32'(a));
         end
         room = pw - (int'(a) % pw);
         mv = (rem < room) ? rem : room;
         ack_n = code;
         bus_rdata = '0;
         for (int l = 0; l < pw; l++) begin
            logic [AW-1:0] la;
            la = (a & ~AW'(pw - 1)) + AW'(l);
            bus_rdata[31 - 8*l -: 8] = mem[la];
         end
         if (wr) begin
            for (int k = 0; k < mv; k++) begin
               logic [AW-1:0] ba;
               ba = a + AW'(k);
               wmem[ba] = bus_wdata[31 - 8*(int'(ba) % pw) -: 8];
            end
         end
         @(negedge clk);
         ack_n = 2'b11;
         rem -= mv;
         a += AW'(mv);
      end
      chk(done == 1'b1 && busy == 1'b0, "R7 done after last acknowledge", {30'd0, done, busy}, 32'd2);
      if (!wr) begin
         exp = '0;
         for (int k = 0; k < n; k++) exp = (exp << 8) | 32'(mem[a0 + AW'(k)]);
         chk(rd_result == exp, "R6 assembled read", rd_result, exp);
      end else begin
         for (int k = 0; k < n; k++) begin
            logic [7:0] eb;
            eb = op_wdata[8*(n-1-k) +: 8];
            chk(wmem[a0 + AW'(k)] == eb, "R5 written byte", 32'(wmem[a0 + AW'(k)]), 32'(eb));
         end
         chk(wmem[a0 + AW'(n)] == 8'hEE, "R5 no stray write", 32'(wmem[a0 + AW'(n)]), 32'hEE);
      end
      @(negedge clk);
      chk(done == 1'b0, "R7 done is one pulse", 32'(done), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1 idle in reset", {30'd0, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {30'd0, busy, done}, 0);
      for (int wr = 0; wr < 2; wr++)
         for (int p = 0; p < 3; p++)
            for (int n = 1; n <= 4; n++)
               for (int o = 0; o < 8; o++)
                  xfer(8'hF8 + 8'(o), n, wr[0], 1 << p, o[0]);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule